// File: doc/BRIEF.md
# Dual-Port DRAM Access Arbiter

This block decides which of three agents uses one shared DRAM controller: Port A, Port B, or the refresh logic. The controller has a single address input path. The grant-to-B output therefore also drives the enables of the external address buffers, so only the selected port's address reaches the controller. Each access is atomic. Once a port or a refresh has been started, it owns the array until the timing logic reports completion on `accDone`.

A port that requests and is not being served sees its wait line asserted. Port B also gets an early transfer acknowledge, which is high while its access is in progress. A lock input lets the port that last held the grant keep the array: the other port and refresh are held off for as long as lock stays high. Outside of lock, a pending refresh beats both ports. When both ports request at once, the port not served last wins, so neither can starve the other. The `FAIR_ALT` parameter set to 0 selects a fixed Port A priority instead.

Top module: `dram_port_arbiter`

## Requirements
- R1: After reset the arbiter is idle, with `grantB`, `ackB` and `refBusy` all low, and no wait is shown when no port requests.
- R2: From idle, a lone request is started at the next clock edge. For Port A, `grantB` is low and `waitA` falls. For Port B, `grantB` rises and `waitB` falls.
- R3: `ackB` is high exactly while a Port B access is in progress. It falls at the clock edge where `accDone` ends that access.
- R4: An access or refresh in progress keeps its owner until `accDone` is sampled high. `grantB` changes only when a new port access starts.
- R5: `waitA` equals `reqA` while Port A is not being served, and `waitB` equals `reqB` while Port B is not being served.
- R6: When idle with lock low, a pending `refReq` wins over both ports. `refBusy` stays high until `accDone`, and both requesting ports see wait.
- R7: When both ports request together (no refresh, no lock), the port not served last wins. After reset Port A is favoured.
- R8: While `lockIn` is high, only the port indicated by `grantB` (1 = B, 0 = A) may start. The other port and refresh stay waiting, even when the locked port is not requesting.
- R9: `accDone` has no effect while the arbiter is idle.
- R10: There is at most one owner at a time: `ackB` and `refBusy` are never high together.
- R11: The arbiter returns to idle for one cycle after every completed access before it grants again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqA | input | 1 | Port A access request (level) |
| reqB | input | 1 | Port B access request (level) |
| refReq | input | 1 | Refresh request (level) |
| lockIn | input | 1 | Hold the array for the last granted port |
| accDone | input | 1 | Current access or refresh is finished |
| grantB | output | 1 | Port B owns the address path (steers external buffers) |
| ackB | output | 1 | Early transfer acknowledge for Port B |
| waitA | output | 1 | Port A is requesting and not being served |
| waitB | output | 1 | Port B is requesting and not being served |
| refBusy | output | 1 | A refresh cycle is in progress |

## Verification
The bench builds the arbiter with the default `FAIR_ALT = 1`. This brings the alternating tie-break within reach: a three-way collision resolves to refresh first, and then to A and B in turn. Lock is exercised with Port B as the last owner while A and refresh both wait, which shows that neither can slip in during the idle gap. A stray `accDone` in idle is followed by a new request, to show that it is dropped without effect.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_A    = 2'd1,
    ST_B    = 2'd2,
    ST_REF  = 2'd3
  } arbState_t;

  typedef struct packed {
    logic startA;
    logic startB;
    logic startRef;
    logic endAcc;
  } arbStrobe_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqA,
  input  logic       reqB,
  input  logic       refReq,
  input  logic       lockIn,
  input  logic       accDone,
  input  logic       grantB,
  input  logic       favorB,
  output arbStrobe_t strobe,
  output logic       waitA,
  output logic       waitB,
  output logic       refBusy
);
  arbState_t state;

  // Winner selection; only evaluated while idle, so owners are never preempted.
  always_comb begin
    strobe = '0;
    if (state == ST_IDLE) begin
      if (lockIn) begin
        if (grantB && reqB)        strobe.startB = 1'b1;
        else if (!grantB && reqA)  strobe.startA = 1'b1;
      end else if (refReq) begin
        strobe.startRef = 1'b1;
      end else if (reqA && reqB) begin
        if (favorB) strobe.startB = 1'b1;
        else        strobe.startA = 1'b1;
      end else if (reqA) begin
        strobe.startA = 1'b1;
      end else if (reqB) begin
        strobe.startB = 1'b1;
      end
    end else begin
      strobe.endAcc = accDone;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strobe.startRef)    state <= ST_REF;
          else if (strobe.startA) state <= ST_A;
          else if (strobe.startB) state <= ST_B;
        end
        default: if (strobe.endAcc) state <= ST_IDLE;
      endcase
    end
  end

  assign waitA   = reqA && (state != ST_A);
  assign waitB   = reqB && (state != ST_B);
  assign refBusy = (state == ST_REF);

  // R4: an owner is kept until completion is reported
  assert_owner_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !accDone) |=> $stable(state));

  // R11: a completed access is always followed by an idle cycle
  assert_idle_gap_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && accDone) |=> (state == ST_IDLE));

  // R6: refresh wins when idle and unlocked
  assert_refresh_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !lockIn && refReq) |=> (state == ST_REF));

  // R8: lock excludes refresh and the other port
  assert_lock_excludes_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && lockIn) |=> (state != ST_REF &&
      state != (grantB ? ST_A : ST_B)));

  // R9: completion while idle changes nothing unless someone requests
  assert_idle_done_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !reqA && !reqB && !refReq) |=> (state == ST_IDLE));
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter bit FAIR_ALT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  arbStrobe_t strobe,
  output logic       grantB,
  output logic       favorB,
  output logic       ackB
);
  logic busyB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantB <= 1'b0;
      busyB  <= 1'b0;
    end else begin
      if (strobe.startB)      grantB <= 1'b1;
      else if (strobe.startA) grantB <= 1'b0;
      if (strobe.startB)      busyB  <= 1'b1;
      else if (strobe.endAcc) busyB  <= 1'b0;
    end
  end

  generate
    if (FAIR_ALT) begin : g_alternate
      logic favorReg;
      always_ff @(posedge clk) begin
        if (!rstN)              favorReg <= 1'b0;
        else if (strobe.startA) favorReg <= 1'b1;
        else if (strobe.startB) favorReg <= 1'b0;
      end
      assign favorB = favorReg;
    end else begin : g_fixed
      assign favorB = 1'b0;
    end
  endgenerate

  assign ackB = busyB;

  // R4: address steering moves only when a port access begins
  assert_grant_steady_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.startA || strobe.startB) |=> $stable(grantB));

  // R3: acknowledge only for a Port B owner
  assert_ack_needs_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    ackB |-> grantB);

  // R3: acknowledge drops after completion
  assert_ack_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ackB && strobe.endAcc) |=> !ackB);
endmodule

// File: rtl/dram_port_arbiter.sv
module dram_port_arbiter
  import arb_pkg::*;
#(
  parameter bit FAIR_ALT = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqA,
  input  logic reqB,
  input  logic refReq,
  input  logic lockIn,
  input  logic accDone,
  output logic grantB,
  output logic ackB,
  output logic waitA,
  output logic waitB,
  output logic refBusy
);
  arbStrobe_t strobe;
  logic       favorB;

  arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqA(reqA), .reqB(reqB), .refReq(refReq),
    .lockIn(lockIn), .accDone(accDone), .grantB(grantB), .favorB(favorB),
    .strobe(strobe), .waitA(waitA), .waitB(waitB), .refBusy(refBusy)
  );

  arb_datapath #(.FAIR_ALT(FAIR_ALT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .grantB(grantB), .favorB(favorB), .ackB(ackB)
  );

  // R10: single owner
  assert_one_owner_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(ackB && refBusy));
endmodule

// File: tb/tb_dram_port_arbiter.sv
module tb_dram_port_arbiter;
  logic clk = 1'b0;
  logic rstN, reqA, reqB, refReq, lockIn, accDone;
  logic grantB, ackB, waitA, waitB, refBusy;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_port_arbiter dut (
    .clk(clk), .rstN(rstN), .reqA(reqA), .reqB(reqB), .refReq(refReq),
    .lockIn(lockIn), .accDone(accDone), .grantB(grantB), .ackB(ackB),
    .waitA(waitA), .waitB(waitB), .refBusy(refBusy)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // end the current access: pulse accDone across one edge
  task automatic finish();
    accDone = 1'b1; step(); accDone = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 grantB", grantB, 1'b0);
    check("R1 ackB", ackB, 1'b0);
    check("R1 refBusy", refBusy, 1'b0);
    check("R1 waitA", waitA, 1'b0);
    check("R1 waitB", waitB, 1'b0);
  endtask

  task automatic t_single_then_pending();
    reqA = 1'b1; step();
    check("R2 waitA", waitA, 1'b0);
    check("R2 grantB A", grantB, 1'b0);
    reqB = 1'b1; step(3);
    check("R5 waitB during A", waitB, 1'b1);
    check("R4 A held waitA", waitA, 1'b0);
    check("R4 grantB stable", grantB, 1'b0);
    reqA = 1'b0; finish();
    check("R11 idle gap ackB", ackB, 1'b0);
    check("R11 idle gap waitB", waitB, 1'b1);
    step();
    check("R2 grantB B", grantB, 1'b1);
    check("R3 ackB on", ackB, 1'b1);
    check("R5 waitB served", waitB, 1'b0);
    reqB = 1'b0; finish();
    check("R3 ackB off", ackB, 1'b0);
    check("R4 grantB kept after B", grantB, 1'b1);
  endtask

  task automatic t_refresh_and_alternate();
    reqA = 1'b1; reqB = 1'b1; refReq = 1'b1; step();
    check("R6 refBusy", refBusy, 1'b1);
    check("R6 waitA", waitA, 1'b1);
    check("R6 waitB", waitB, 1'b1);
    check("R10 no ackB in refresh", ackB, 1'b0);
    step(2);
    check("R4 refresh held", refBusy, 1'b1);
    refReq = 1'b0; finish();
    check("R6 refresh ended", refBusy, 1'b0);
    step();
    // last served was B, so A wins the tie
    check("R7 A wins tie waitA", waitA, 1'b0);
    check("R7 A wins tie waitB", waitB, 1'b1);
    finish(); step();
    check("R7 B wins next tie ackB", ackB, 1'b1);
    check("R7 B wins next tie waitA", waitA, 1'b1);
    reqA = 1'b0; reqB = 1'b0; finish();
  endtask

  task automatic t_lock();
    // last port owner is B here
    lockIn = 1'b1; reqA = 1'b1; refReq = 1'b1; step(3);
    check("R8 refresh blocked", refBusy, 1'b0);
    check("R8 A blocked", waitA, 1'b1);
    check("R8 grantB stays B", grantB, 1'b1);
    reqB = 1'b1; step();
    check("R8 locked B starts", ackB, 1'b1);
    reqB = 1'b0; finish();
    lockIn = 1'b0; step();
    check("R6 refresh after unlock", refBusy, 1'b1);
    refReq = 1'b0; finish(); step();
    check("R2 A after refresh", waitA, 1'b0);
    check("R2 A grantB low", grantB, 1'b0);
    reqA = 1'b0; finish();
  endtask

  task automatic t_idle_done();
    accDone = 1'b1; step(2);
    check("R9 idle refBusy", refBusy, 1'b0);
    check("R9 idle ackB", ackB, 1'b0);
    check("R9 idle grantB", grantB, 1'b0);
    accDone = 1'b0; reqB = 1'b1; step();
    check("R9 B starts after stray done", ackB, 1'b1);
    reqB = 1'b0; finish();
  endtask

  initial begin
    rstN = 1'b0; reqA = 1'b0; reqB = 1'b0; refReq = 1'b0;
    lockIn = 1'b0; accDone = 1'b0;
    step(3);
    rstN = 1'b1;
    step();
    t_reset();
    t_single_then_pending();
    t_refresh_and_alternate();
    t_lock();
    t_idle_done();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule